// File: doc/BRIEF.md
# Shared-Bus Coprocessor Data Bridge

This block joins a second processor, one whose bus cycles do not look like those of a 65xx part, to a shared 65xx-style system bus. The system bus alternates between two owners. A grant input marks the phase in which the processor side holds the bus. In the other phase the video controller or an external DMA engine drives it. The bridge keeps running the coprocessor through both phases. It lets data cross to the bus only while the processor side holds the grant.

Address and write data leave the bridge with explicit output enables, which stand in for tri-state buffers. The address is enabled for any access while the grant is held. Write data is enabled only for a write under the grant. Read data reaches the coprocessor through a transparent latch. The latch is open during a read in the granted phase while the 1 MHz system clock is high. Once it closes, it holds the captured value.

A wait output stretches any access that begins outside a usable bus window. The access is held until a granted, clock-high cycle has been seen. Since only half of the bus time can carry transfers, a 4 MHz coprocessor gets roughly the bus throughput of a 2 MHz part.

Top module: `cpu_bus_bridge`

## Requirements
- R1: `bus_addr_oe` is high exactly when `bus_grant` is high and at least one of `cpu_rd_en` or `cpu_wr_en` is high.
- R2: `bus_addr` equals `cpu_addr` while `bus_addr_oe` is high, and is all zeros otherwise.
- R3: `bus_data_oe` is high exactly when `bus_grant` and `cpu_wr_en` are both high, whatever the level of `sys_1m`. `bus_wdata` equals `cpu_wdata` while `bus_data_oe` is high, and is all zeros otherwise.
- R4: The read latch is open when `cpu_rd_en`, `bus_grant` and `sys_1m` are all high. While it is open, `cpu_rdata` follows `bus_rdata` in the same cycle, and each rising `clk` edge captures that value.
- R5: While the latch is closed, `cpu_rdata` keeps the last captured value. Changes on `bus_rdata`, write accesses and a read under the grant with `sys_1m` low leave it unchanged, up to the next opening.
- R6: `cpu_wait` is high when an access (`cpu_rd_en` or `cpu_wr_en`) is active, the current cycle is not a window (`bus_grant` and `sys_1m` both high), and no window has been seen since the access began. Without an access, `cpu_wait` is low.
- R7: After a window cycle has been seen during an access, `cpu_wait` stays low for as long as that access stays active. Once `cpu_rd_en` and `cpu_wr_en` are both low, the next access starts stretching again.
- R8: While `rst_n` is low and right after it rises, the held read value is zero and no window is recorded. As a result, `cpu_rdata` reads zero while the latch is closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Coprocessor clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_grant | input | 1 | High while the processor side owns the shared bus |
| sys_1m | input | 1 | Level of the 1 MHz system clock |
| cpu_rd_en | input | 1 | Coprocessor read access active |
| cpu_wr_en | input | 1 | Coprocessor write access active |
| cpu_addr | input | AW | Coprocessor address |
| cpu_wdata | input | DW | Coprocessor write data |
| cpu_rdata | output | DW | Read data presented to the coprocessor |
| cpu_wait | output | 1 | Stretch request to the coprocessor |
| bus_addr | output | AW | Address toward the shared bus |
| bus_addr_oe | output | 1 | Address output enable |
| bus_wdata | output | DW | Write data toward the shared bus |
| bus_data_oe | output | 1 | Write data output enable |
| bus_rdata | input | DW | Data present on the shared bus |

## Verification
The assertions assume that the coprocessor never raises read and write in the same cycle. They also assume that inputs change only away from the rising edge of `clk`. The bench drives every input shortly after a falling edge and never sets both access strobes at once. The bench samples each output before the next rising edge. Grant and 1 MHz levels are chosen freely cycle by cycle, so the stretch logic is exercised in every phase combination.

// File: rtl/bridge_pkg.sv
package bridge_pkg;

    // Bus phase seen by the coprocessor side
    typedef enum logic [1:0] {
        PH_FOREIGN = 2'd0,  // video or DMA owns the bus
        PH_SETUP   = 2'd1,  // granted, 1 MHz clock low
        PH_WINDOW  = 2'd2   // granted, 1 MHz clock high: transfers complete
    } bus_phase_e;

    function automatic bus_phase_e phase_of(input logic grant, input logic clk1m);
        if (!grant)     return PH_FOREIGN;
        else if (clk1m) return PH_WINDOW;
        else            return PH_SETUP;
    endfunction

endpackage

// File: rtl/bridge_gate.sv
module bridge_gate #(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  bridge_pkg::bus_phase_e phase,
    input  logic                   rd_en,
    input  logic                   wr_en,
    input  logic [AW-1:0]          addr_in,
    input  logic [DW-1:0]          wdata_in,
    output logic [AW-1:0]          addr_out,
    output logic                   addr_oe,
    output logic [DW-1:0]          wdata_out,
    output logic                   data_oe
);
    import bridge_pkg::*;

    logic owned;

    always_comb begin
        owned     = (phase != PH_FOREIGN);
        addr_oe   = owned && (rd_en || wr_en);
        data_oe   = owned && wr_en;
        addr_out  = addr_oe ? addr_in  : '0;
        wdata_out = data_oe ? wdata_in : '0;
    end

endmodule

// File: rtl/bridge_rd_latch.sv
module bridge_rd_latch #(
    parameter int DW = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  bridge_pkg::bus_phase_e phase,
    input  logic                   rd_en,
    input  logic [DW-1:0]          bus_in,
    output logic [DW-1:0]          cpu_out
);
    import bridge_pkg::*;

    typedef struct packed {
        logic [DW-1:0] held;
    } lat_t;

    lat_t lat_d, lat_q;
    logic open_w;

    always_comb begin
        open_w = rd_en && (phase == PH_WINDOW);
        lat_d  = lat_q;
        if (open_w) begin
            lat_d.held = bus_in;
        end
        cpu_out = open_w ? bus_in : lat_q.held;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_q <= '0;
        end else begin
            lat_q <= lat_d;
        end
    end

endmodule

// File: rtl/bridge_stretch.sv
module bridge_stretch (
    input  logic                   clk,
    input  logic                   rst_n,
    input  bridge_pkg::bus_phase_e phase,
    input  logic                   rd_en,
    input  logic                   wr_en,
    output logic                   wait_o
);
    import bridge_pkg::*;

    typedef struct packed {
        logic done;
    } st_t;

    st_t  st_d, st_q;
    logic busy;
    logic win;

    always_comb begin
        busy      = rd_en || wr_en;
        win       = (phase == PH_WINDOW);
        st_d.done = busy && (st_q.done || win);
        wait_o    = busy && !win && !st_q.done;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/cpu_bus_bridge.sv
module cpu_bus_bridge #(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_grant,
    input  logic          sys_1m,
    input  logic          cpu_rd_en,
    input  logic          cpu_wr_en,
    input  logic [AW-1:0] cpu_addr,
    input  logic [DW-1:0] cpu_wdata,
    output logic [DW-1:0] cpu_rdata,
    output logic          cpu_wait,
    output logic [AW-1:0] bus_addr,
    output logic          bus_addr_oe,
    output logic [DW-1:0] bus_wdata,
    output logic          bus_data_oe,
    input  logic [DW-1:0] bus_rdata
);
    import bridge_pkg::*;

    bus_phase_e phase;

    always_comb begin
        phase = phase_of(bus_grant, sys_1m);
    end

    bridge_gate #(.AW(AW), .DW(DW)) u_gate (
        .phase     (phase),
        .rd_en     (cpu_rd_en),
        .wr_en     (cpu_wr_en),
        .addr_in   (cpu_addr),
        .wdata_in  (cpu_wdata),
        .addr_out  (bus_addr),
        .addr_oe   (bus_addr_oe),
        .wdata_out (bus_wdata),
        .data_oe   (bus_data_oe)
    );

    bridge_rd_latch #(.DW(DW)) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .phase   (phase),
        .rd_en   (cpu_rd_en),
        .bus_in  (bus_rdata),
        .cpu_out (cpu_rdata)
    );

    bridge_stretch u_stretch (
        .clk    (clk),
        .rst_n  (rst_n),
        .phase  (phase),
        .rd_en  (cpu_rd_en),
        .wr_en  (cpu_wr_en),
        .wait_o (cpu_wait)
    );

endmodule

// File: rtl/cpu_bus_bridge_chk.sv
module cpu_bus_bridge_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_grant,
    input logic          sys_1m,
    input logic          cpu_rd_en,
    input logic          cpu_wr_en,
    input logic [DW-1:0] cpu_rdata,
    input logic          cpu_wait,
    input logic          bus_addr_oe,
    input logic          bus_data_oe
);
    logic acc;
    logic win;
    logic open_c;

    always_comb begin
        acc    = cpu_rd_en || cpu_wr_en;
        win    = bus_grant && sys_1m;
        open_c = cpu_rd_en && win;
    end

    // R1
    addr_only_granted_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_addr_oe |-> (bus_grant && acc));

    // R3
    wdata_only_granted_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_data_oe |-> (bus_grant && cpu_wr_en));

    // R5
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !open_c |=> (open_c || $stable(cpu_rdata)));

    // R6
    no_wait_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_wait |-> (acc && !win));

    // R7
    no_wait_after_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && win) |=> (!acc || !cpu_wait));

endmodule

bind cpu_bus_bridge cpu_bus_bridge_chk #(.DW(DW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_grant   (bus_grant),
    .sys_1m      (sys_1m),
    .cpu_rd_en   (cpu_rd_en),
    .cpu_wr_en   (cpu_wr_en),
    .cpu_rdata   (cpu_rdata),
    .cpu_wait    (cpu_wait),
    .bus_addr_oe (bus_addr_oe),
    .bus_data_oe (bus_data_oe)
);

// File: tb/sim_cpu_bus_bridge.sv
module sim_cpu_bus_bridge;
    localparam int AW = 16;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          bus_grant, sys_1m, cpu_rd_en, cpu_wr_en;
    logic [AW-1:0] cpu_addr;
    logic [DW-1:0] cpu_wdata, bus_rdata;
    logic [DW-1:0] cpu_rdata;
    logic          cpu_wait, bus_addr_oe, bus_data_oe;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    cpu_bus_bridge #(.AW(AW), .DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_grant(bus_grant), .sys_1m(sys_1m),
        .cpu_rd_en(cpu_rd_en), .cpu_wr_en(cpu_wr_en), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_wait(cpu_wait),
        .bus_addr(bus_addr), .bus_addr_oe(bus_addr_oe), .bus_wdata(bus_wdata),
        .bus_data_oe(bus_data_oe), .bus_rdata(bus_rdata)
    );

    // {grant, 1m, rd, wr, addr[16], wdata[8], bus_rdata[8], exp_addr_oe, exp_data_oe}
    localparam int VW = 38;
    localparam int NV = 8;
    localparam logic [VW-1:0] VEC [NV] = '{
        {4'b1110, 16'h1234, 8'h11, 8'hAA, 2'b10},
        {4'b1101, 16'h2345, 8'h22, 8'hBB, 2'b11},
        {4'b0110, 16'h3456, 8'h33, 8'hCC, 2'b00},
        {4'b0001, 16'h4567, 8'h44, 8'hDD, 2'b00},
        {4'b1000, 16'h5678, 8'h55, 8'hEE, 2'b00},
        {4'b1100, 16'h6789, 8'h66, 8'h11, 2'b00},
        {4'b0101, 16'h789A, 8'h77, 8'h22, 2'b00},
        {4'b1001, 16'hFFFF, 8'h88, 8'h33, 2'b11}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic g, input logic p, input logic r, input logic w,
                         input logic [AW-1:0] a, input logic [DW-1:0] wd,
                         input logic [DW-1:0] bd);
        bus_grant = g; sys_1m = p; cpu_rd_en = r; cpu_wr_en = w;
        cpu_addr = a; cpu_wdata = wd; bus_rdata = bd;
        #2;
    endtask

    task automatic next_cycle();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        drive(1, 1, 1, 0, 16'h0, 8'h0, 8'h5A);
        repeat (3) next_cycle();
        rst_n = 1'b1;
        drive(0, 0, 0, 0, 16'h0, 8'h0, 8'h5A);
        // R8: nothing held after reset, latch closed
        check("R8 rdata after reset", 32'(cpu_rdata), 32'h0);
        check("R8 wait after reset", 32'(cpu_wait), 32'h0);
        check("R1 addr_oe idle", 32'(bus_addr_oe), 32'h0);
        next_cycle();

        // Table: gating and open-latch pass-through
        for (int i = 0; i < NV; i++) begin
            logic [VW-1:0] v;
            v = VEC[i];
            drive(v[37], v[36], v[35], v[34], v[33:18], v[17:10], v[9:2]);
            check("R1 addr_oe", 32'(bus_addr_oe), 32'(v[1]));
            check("R2 bus_addr", 32'(bus_addr), v[1] ? 32'(v[33:18]) : 32'h0);
            check("R3 data_oe", 32'(bus_data_oe), 32'(v[0]));
            check("R3 bus_wdata", 32'(bus_wdata), v[0] ? 32'(v[17:10]) : 32'h0);
            if (v[37] && v[36] && v[35])
                check("R4 open latch follows bus", 32'(cpu_rdata), 32'(v[9:2]));
            next_cycle();
            drive(0, 0, 0, 0, 16'h0, 8'h0, 8'h0);
            next_cycle();
        end

        // Latch capture and hold
        drive(1, 1, 1, 0, 16'h10, 8'h0, 8'hA5);
        check("R4 open latch", 32'(cpu_rdata), 32'hA5);
        next_cycle();
        drive(1, 0, 1, 0, 16'h10, 8'h0, 8'h3C);
        check("R5 hold with 1m low", 32'(cpu_rdata), 32'hA5);
        next_cycle();
        drive(0, 1, 1, 0, 16'h10, 8'h0, 8'h3C);
        check("R5 hold without grant", 32'(cpu_rdata), 32'hA5);
        next_cycle();
        drive(1, 1, 0, 1, 16'h10, 8'h99, 8'hFF);
        check("R5 hold across write", 32'(cpu_rdata), 32'hA5);
        next_cycle();
        drive(1, 1, 0, 0, 16'h10, 8'h0, 8'hFF);
        check("R5 hold when idle", 32'(cpu_rdata), 32'hA5);
        next_cycle();
        drive(1, 1, 1, 0, 16'h10, 8'h0, 8'h77);
        next_cycle();
        drive(0, 0, 0, 0, 16'h10, 8'h0, 8'h00);
        check("R4 new capture held", 32'(cpu_rdata), 32'h77);
        next_cycle();

        // Stretching
        drive(0, 0, 1, 0, 16'h20, 8'h0, 8'h0);
        check("R6 wait foreign phase", 32'(cpu_wait), 32'h1);
        next_cycle();
        drive(0, 1, 1, 0, 16'h20, 8'h0, 8'h0);
        check("R6 wait foreign 1m high", 32'(cpu_wait), 32'h1);
        next_cycle();
        drive(1, 0, 1, 0, 16'h20, 8'h0, 8'h0);
        check("R6 wait granted 1m low", 32'(cpu_wait), 32'h1);
        next_cycle();
        drive(1, 1, 1, 0, 16'h20, 8'h0, 8'h0);
        check("R6 no wait in window", 32'(cpu_wait), 32'h0);
        next_cycle();
        drive(0, 0, 1, 0, 16'h20, 8'h0, 8'h0);
        check("R7 no wait after window", 32'(cpu_wait), 32'h0);
        next_cycle();
        drive(0, 0, 0, 0, 16'h20, 8'h0, 8'h0);
        check("R6 no wait when idle", 32'(cpu_wait), 32'h0);
        next_cycle();
        drive(0, 0, 0, 1, 16'h20, 8'h0, 8'h0);
        check("R7 next access stretches", 32'(cpu_wait), 32'h1);
        next_cycle();
        drive(1, 1, 0, 1, 16'h20, 8'h0, 8'h0);
        next_cycle();
        drive(1, 0, 0, 1, 16'h20, 8'h0, 8'h0);
        check("R7 write done stays unstretched", 32'(cpu_wait), 32'h0);
        next_cycle();

        // Reset mid-access clears the recorded window
        rst_n = 1'b0;
        next_cycle();
        rst_n = 1'b1;
        drive(0, 0, 0, 1, 16'h20, 8'h0, 8'h0);
        check("R8 window cleared by reset", 32'(cpu_wait), 32'h1);
        check("R8 held value cleared", 32'(cpu_rdata), 32'h0);
        next_cycle();

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule